// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the address a synchronous memory core uses during a four-beat burst. On a load cycle it takes a full external address. The two low bits become the start of the burst. The upper bits are held and passed through unchanged for the rest of the burst. On each advance cycle it steps the two low bits to the next beat. It wraps back to the start value after the fourth beat, so a fifth advance-free access is never needed to return.

Two beat orders are supported. Linear order adds the beat count to the start modulo four. Interleaved order XORs the beat count into the start. The order is picked by a select pin that is sampled only on load, so a burst keeps one order from start to end. An active-low clock enable suspends the sequencer: while it is high, nothing changes. Classifying cycles as reads, writes, dummy reads or aborts is left to the surrounding controller. The sequencer steps on every advance cycle regardless of that classification.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset the output address is all zeros and the beat count is zero, so an advance straight after reset produces low bits 01 in linear order.
- R2: On a rising edge with clk_en_n low and adv_ld low, the whole of ext_addr is captured, and mem_addr equals it from just after that edge.
- R3: With the order latched as linear (ord_sel low at load), each enabled edge with adv_ld high makes the low bits equal (start + beat) mod 4. For example, a start of 01 gives 01, 10, 11, 00.
- R4: With the order latched as interleaved (ord_sel high at load), the low bits equal start XOR beat. For example, a start of 01 gives 01, 00, 11, 10.
- R5: The fourth advance after a load returns the low bits to the loaded start value in either order.
- R6: On a rising edge with clk_en_n high, mem_addr and the beat position do not change, whatever adv_ld, ord_sel and ext_addr carry.
- R7: A change of ord_sel during a burst has no effect on the sequence until the next load.
- R8: During advance cycles, the upper bits of mem_addr (all bits above bit 1) stay at the values captured on the last load, and ext_addr is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en_n | input | 1 | Active-low clock enable; high suspends the sequencer |
| adv_ld | input | 1 | High: advance to the next beat; low: load a new start |
| ord_sel | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| ext_addr | input | UPPER_W+2 | External address, sampled on load |
| mem_addr | output | UPPER_W+2 | Address presented to the memory core |

## Verification
A corrupted beat count shows on the very next enabled edge as a low-bit pair out of sequence. The same fault can also show as a burst that fails to come back to its start on the fourth advance. A wrongly latched order flag turns the second beat of a burst odd in its start bit: linear start 01 goes to 10, interleaved to 00. So an order fault is visible one cycle after the load. A stall leak is visible in the same cycle as the suspended edge, because the address output is a direct function of the held registers. A lost upper field shows on the first advance after the load.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;
  typedef enum logic {ORD_LINEAR = 1'b0, ORD_XOR = 1'b1} order_e;

  // Address of a beat given the burst start and order.
  function automatic beat_t map_beat(beat_t start, beat_t beat, order_e ord);
    beat_t r;
    if (ord == ORD_XOR) r = start ^ beat;
    else                r = beat_t'(start + beat);
    return r;
  endfunction

  // Next beat position; wraps naturally modulo four.
  function automatic beat_t next_beat(beat_t beat);
    return beat_t'(beat + beat_t'(1));
  endfunction
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_evt,
  input  logic  adv_evt,
  output beat_t beat_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)        beat_q <= '0;
    else if (load_evt) beat_q <= '0;
    else if (adv_evt)  beat_q <= next_beat(beat_q);
  end

  // R5: after the last beat an advance returns to beat zero
  assert_beat_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_evt && !load_evt && beat_q == beat_t'(3)) |=> beat_q == '0);

  // R6: no event means no movement
  assert_beat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_evt && !load_evt) |=> $stable(beat_q));
endmodule

// File: rtl/burst_start_reg.sv
module burst_start_reg
  import burst_seq_pkg::*;
#(
  parameter int UPPER_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_evt,
  input  logic [UPPER_W+BEAT_W-1:0] ext_addr,
  input  logic               ord_sel,
  output beat_t              start_q,
  output logic [UPPER_W-1:0] upper_q,
  output order_e             ord_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      upper_q <= '0;
      ord_q   <= ORD_LINEAR;
    end else if (load_evt) begin
      start_q <= ext_addr[BEAT_W-1:0];
      upper_q <= ext_addr[UPPER_W+BEAT_W-1:BEAT_W];
      ord_q   <= order_e'(ord_sel);
    end
  end

  // R7: the latched order only moves on a load
  assert_order_static_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(ord_q));
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int UPPER_W = 8,
  localparam int AW = UPPER_W + BEAT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en_n,
  input  logic          adv_ld,
  input  logic          ord_sel,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] mem_addr
);
  // Named events for the checks below
  logic load_evt;
  logic adv_evt;
  assign load_evt = !clk_en_n && !adv_ld;
  assign adv_evt  = !clk_en_n &&  adv_ld;

  beat_t              beat_q;
  beat_t              start_q;
  logic [UPPER_W-1:0] upper_q;
  order_e             ord_q;
  beat_t              low_addr;

  burst_beat_ctr u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_evt (load_evt),
    .adv_evt  (adv_evt),
    .beat_q   (beat_q)
  );

  burst_start_reg #(.UPPER_W(UPPER_W)) u_start (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_evt (load_evt),
    .ext_addr (ext_addr),
    .ord_sel  (ord_sel),
    .start_q  (start_q),
    .upper_q  (upper_q),
    .ord_q    (ord_q)
  );

  assign low_addr = map_beat(start_q, beat_q, ord_q);
  assign mem_addr = {upper_q, low_addr};

  // R2: a load shows the captured address after the edge
  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> mem_addr == $past(ext_addr));

  // R3: linear advance steps the low bits by one
  assert_linear_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_evt && ord_q == ORD_LINEAR) |=>
      mem_addr[BEAT_W-1:0] == beat_t'($past(mem_addr[BEAT_W-1:0]) + beat_t'(1)));

  // R4: interleaved advance flips bit 0, plus bit 1 when leaving an odd beat
  assert_xor_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_evt && ord_q == ORD_XOR) |=>
      (mem_addr[BEAT_W-1:0] ^ $past(mem_addr[BEAT_W-1:0])) ==
      ($past(beat_q[0]) ? 2'b11 : 2'b01));

  // R6: suspended edge leaves the output untouched
  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> $stable(mem_addr));

  // R8: upper bits do not follow ext_addr during advances
  assert_upper_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt |=> $stable(mem_addr[AW-1:BEAT_W]));
endmodule

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int UW = 8;
  localparam int AW = UW + 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          clk_en_n;
  logic          adv_ld;
  logic          ord_sel;
  logic [AW-1:0] ext_addr;
  logic [AW-1:0] mem_addr;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq #(.UPPER_W(UW)) u0 (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .adv_ld(adv_ld),
    .ord_sel(ord_sel), .ext_addr(ext_addr), .mem_addr(mem_addr)
  );

  function automatic logic [1:0] expect_low(logic [1:0] s, int k, bit ilv);
    logic [1:0] kk;
    kk = 2'(k % 4);
    if (ilv) return s ^ kk;
    return 2'((int'(s) + k) % 4);
  endfunction

  task automatic check(string req, logic [AW-1:0] exp);
    n_run++;
    if (mem_addr !== exp) begin
      n_fail++;
      $display("FAIL %s: mem_addr=%h expected=%h", req, mem_addr, exp);
    end
  endtask

  // One clock: drive at the falling edge, settle after the rising edge
  task automatic step(bit ce_n, bit adv, bit ord, logic [AW-1:0] a);
    @(negedge clk);
    clk_en_n = ce_n; adv_ld = adv; ord_sel = ord; ext_addr = a;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; clk_en_n = 1'b1; adv_ld = 1'b0; ord_sel = 1'b0; ext_addr = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset value", '0);
    @(negedge clk); rst_n = 1'b1;
    step(1'b0, 1'b1, 1'b0, 10'h3FF);
    check("R1 advance after reset", 10'h001);
  endtask

  task automatic t_burst(bit ilv, logic [1:0] s, logic [UW-1:0] up, string req);
    step(1'b0, 1'b0, ilv, {up, s});
    check("R2 load", {up, s});
    for (int k = 1; k <= 4; k++) begin
      step(1'b0, 1'b1, ~ilv, {~up, ~s});
      check(k == 4 ? "R5 wrap to start" : req, {up, expect_low(s, k, ilv)});
    end
  endtask

  task automatic t_stall;
    step(1'b0, 1'b0, 1'b0, 10'h2A2);
    step(1'b0, 1'b1, 1'b0, '0);
    check("R3 first advance", 10'h2A3);
    for (int i = 0; i < 3; i++) begin
      step(1'b1, i[0], 1'b1, 10'h155);
      check("R6 stalled edge", 10'h2A3);
    end
    step(1'b0, 1'b1, 1'b0, '0);
    check("R6 resume after stall", 10'h2A0);
  endtask

  task automatic t_order_change;
    step(1'b0, 1'b0, 1'b1, 10'h0C6);
    step(1'b0, 1'b1, 1'b0, '0);
    check("R7 order kept", {8'h31, 2'b10 ^ 2'b01});
    step(1'b0, 1'b1, 1'b0, '0);
    check("R7 order kept", {8'h31, 2'b10 ^ 2'b10});
    step(1'b0, 1'b0, 1'b0, 10'h0C6);
    step(1'b0, 1'b1, 1'b1, '0);
    check("R7 new order at load", {8'h31, 2'b11});
  endtask

  task automatic t_reload_mid;
    step(1'b0, 1'b0, 1'b0, 10'h101);
    step(1'b0, 1'b1, 1'b0, '0);
    step(1'b0, 1'b0, 1'b0, 10'h3FE);
    check("R2 reload mid burst", 10'h3FE);
    step(1'b0, 1'b1, 1'b0, 10'h000);
    check("R8 upper kept", 10'h3FF);
  endtask

  initial begin
    t_reset();
    t_burst(1'b0, 2'b01, 8'hA5, "R3 linear beat");
    t_burst(1'b1, 2'b01, 8'h5A, "R4 interleaved beat");
    t_burst(1'b0, 2'b11, 8'h3C, "R3 linear beat");
    t_burst(1'b1, 2'b10, 8'hC3, "R4 interleaved beat");
    t_stall();
    t_order_change();
    t_reload_mid();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: done=0 expected=1");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule